// File: doc/BRIEF.md
# Parallel-to-Serial Output Serializer with Cascade and Enable Serializer

This block turns a parallel word into a serial bit stream for an output pin. A word is captured on a load strobe and then shifted out, lowest-indexed bit first. The load strobe is a clock enable on the fast bit clock and marks each edge of the divided clock. In single data rate (SDR) mode one bit leaves per fast cycle. In double data rate (DDR) mode two bits leave per fast cycle. The serial output is a two-bit pair `{late, early}` for the rising-half and falling-half slots of a DDR output stage. In SDR mode both slots carry the same bit.

One instance handles words of up to six bits. Wider words use two identical instances, one in the master role and one in the slave role. The slave holds the upper bits and passes them into the master through dedicated cascade ports, one bit per fast cycle in SDR mode and two in DDR mode. A second, smaller serializer produces the output-enable stream that goes with the data. It can run in one of three ways: a combinational pass-through, a value held for the whole word, or four DDR bits. Illegal combinations of mode, width and role stop elaboration.

Top module: `par2ser_out`

## Requirements
- R1: Data width legality. The legal widths are 2, 3, 4, 5, 6, 7 and 8 in SDR mode and 4, 6, 8 and 10 in DDR mode. Widths above 6 also need the cascade. Any other combination, or the slave role with a width of 6 or less, stops elaboration with an error.
- R2: Enable width legality. The pass-through and held modes take an enable width of exactly 1. The DDR enable mode takes exactly 4, and only with DDR data of width 4. Any other setting stops elaboration.
- R3: While `rst` is high, `ser_q` is 2'b00 and `tri_q` is 2'b11. An enable value of 1 requests high impedance.
- R4: On a rising `clk` edge where `div_tick` is 1, the instance captures `par_d`. In the cycle after that edge, `ser_q` presents the first slot(s) of the new word.
- R5: SDR order. In the j-th cycle after the load edge (j = 0 .. N-1), both bits of `ser_q` equal word bit j.
- R6: DDR order. In the j-th cycle after the load edge (j = 0 .. N/2-1), `ser_q[0]` equals word bit 2j and `ser_q[1]` equals word bit 2j+1.
- R7: Cascade. The master's `par_d[5:0]` holds word bits 5..0. The slave's `par_d[W-7:0]` holds word bits W-1..6. The slave's `casc_out[0]` (and `casc_out[1]` in DDR mode) carries its next bit(s) to send. The master's `casc_in` feeds its top positions. Together the pair forms 7:1 and 8:1 SDR and 8:1 and 10:1 DDR streams.
- R8: `div_tick` comes exactly once every N fast cycles in SDR mode and every N/2 in DDR mode. The register reloads only on that strobe.
- R9: Held enable mode. `tri_q` shows `{tri_d[0], tri_d[0]}` as captured at the load edge, and holds it until the next load.
- R10: DDR enable mode. In cycle j after the load edge, `tri_q[0]` equals the captured `tri_d[2j]` and `tri_q[1]` equals `tri_d[2j+1]`.
- R11: Pass-through enable mode. Outside reset, `tri_q` equals `{tri_d[0], tri_d[0]}` in the same cycle, with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| div_tick | input | 1 | Load strobe marking a divided-clock edge |
| par_d | input | 6 | Parallel data lane for this instance |
| tri_d | input | 4 | Parallel output-enable bits |
| casc_in | input | 2 | Bits shifted in from the slave (master role) |
| ser_q | output | 2 | Serial data pair {late, early} |
| tri_q | output | 2 | Serial enable pair {late, early}, 1 = high impedance |
| casc_out | output | 2 | Next bits offered to the master (slave role) |

## Verification
The bench runs eleven configurations side by side: every legal SDR and DDR width, including the cascaded 7, 8 and 10 bit pairs, and all three enable modes. Each one is compared cycle by cycle with an arithmetic model of the bit order.

- An off-by-one in the load alignment would shift the whole stream by one slot.
- A swapped DDR pair would interleave odd and even bits.
- A cascade fed from the wrong slave bits, or one that shifts by the wrong step, would corrupt only the upper bits of wide words.
- A mid-run reset checks that the outputs drop to their reset values and that streaming restarts cleanly.
- A sweep of the package legality functions checks that only the permitted width and mode pairs are accepted.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

    localparam int P2S_LANE  = 6;
    localparam int P2S_TRI_W = 4;

    typedef enum logic [1:0] {
        TRI_BUF = 2'd0,
        TRI_SDR = 2'd1,
        TRI_DDR = 2'd2
    } tri_mode_e;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;

    typedef struct packed {
        logic late;
        logic early;
    } slot_pair_t;

    function automatic bit data_width_ok(input bit ddr, input int w);
        if (ddr) return (w == 4) || (w == 6) || (w == 8) || (w == 10);
        return (w >= 2) && (w <= 8);
    endfunction

    function automatic bit needs_cascade(input int w);
        return w > P2S_LANE;
    endfunction

    function automatic bit tri_width_ok(input tri_mode_e tm, input bit ddr,
                                        input int dw, input int tw);
        if (tm == TRI_DDR) return (tw == 4) && ddr && (dw == 4);
        return tw == 1;
    endfunction

    function automatic bit cfg_legal(input bit ddr, input int w, input role_e role,
                                     input tri_mode_e tm, input int tw);
        bit role_ok;
        role_ok = (role == ROLE_MASTER) || needs_cascade(w);
        return data_width_ok(ddr, w) && role_ok && tri_width_ok(tm, ddr, w, tw);
    endfunction

    function automatic int local_bits(input role_e role, input int w);
        if (role == ROLE_SLAVE) return (w > P2S_LANE) ? (w - P2S_LANE) : 1;
        return (w > P2S_LANE) ? P2S_LANE : w;
    endfunction

endpackage

// File: rtl/p2s_data_shifter.sv
module p2s_data_shifter
    import p2s_pkg::*;
#(
    parameter bit    DDR_MODE = 1'b0,
    parameter int    WORD_W   = 4,
    parameter role_e ROLE     = ROLE_MASTER
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [P2S_LANE-1:0] par_d,
    input  logic [1:0]          casc_in,
    output slot_pair_t          pair,
    output logic [1:0]          casc_out
);
    localparam int  STEP     = DDR_MODE ? 2 : 1;
    localparam int  LOC      = local_bits(ROLE, WORD_W);
    localparam bit  USE_CASC = (ROLE == ROLE_MASTER) && (WORD_W > P2S_LANE);

    logic [LOC-1:0]  sreg;
    logic [LOC-1:0]  sreg_nxt;
    logic [STEP-1:0] fill;

    generate
        if (USE_CASC) begin : g_fill_casc
            assign fill = casc_in[STEP-1:0];
        end else begin : g_fill_zero
            assign fill = '0;
        end

        if (LOC > STEP) begin : g_shift_long
            assign sreg_nxt = {fill, sreg[LOC-1:STEP]};
        end else begin : g_shift_short
            assign sreg_nxt = fill;
        end

        if (LOC < P2S_LANE) begin : g_spare_lane
            logic unused_lane;
            assign unused_lane = ^par_d[P2S_LANE-1:LOC];
        end

        if (DDR_MODE) begin : g_out_ddr
            assign pair.early = sreg[0];
            assign pair.late  = sreg[1];
            assign casc_out   = sreg[1:0];
        end else begin : g_out_sdr
            logic unused_casc_hi;
            assign unused_casc_hi = casc_in[1];
            assign pair.early = sreg[0];
            assign pair.late  = sreg[0];
            assign casc_out   = {1'b0, sreg[0]};
        end

        if (!USE_CASC) begin : g_casc_idle
            logic unused_casc;
            assign unused_casc = ^casc_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= par_d[LOC-1:0];
        end else begin
            sreg <= sreg_nxt;
        end
    end

endmodule

// File: rtl/p2s_tri_shifter.sv
module p2s_tri_shifter
    import p2s_pkg::*;
#(
    parameter tri_mode_e TRI_MODE = TRI_SDR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [P2S_TRI_W-1:0] tri_d,
    output slot_pair_t           pair
);
    generate
        if (TRI_MODE == TRI_BUF) begin : g_buf
            logic unused_buf;
            assign unused_buf = ^{clk, load, tri_d[P2S_TRI_W-1:1]};
            assign pair.early = rst ? 1'b1 : tri_d[0];
            assign pair.late  = rst ? 1'b1 : tri_d[0];
        end else if (TRI_MODE == TRI_SDR) begin : g_held
            logic held;
            logic unused_held;
            assign unused_held = ^tri_d[P2S_TRI_W-1:1];
            always_ff @(posedge clk) begin
                if (rst)       held <= 1'b1;
                else if (load) held <= tri_d[0];
            end
            assign pair.early = held;
            assign pair.late  = held;
        end else begin : g_ddr
            logic [P2S_TRI_W-1:0] treg;
            always_ff @(posedge clk) begin
                if (rst)       treg <= '1;
                else if (load) treg <= tri_d;
                else           treg <= {2'b11, treg[P2S_TRI_W-1:2]};
            end
            assign pair.early = treg[0];
            assign pair.late  = treg[1];
        end
    endgenerate

endmodule

// File: rtl/par2ser_out.sv
module par2ser_out
    import p2s_pkg::*;
#(
    parameter bit        DDR_MODE = 1'b0,
    parameter int        WORD_W   = 4,
    parameter role_e     ROLE     = ROLE_MASTER,
    parameter tri_mode_e TRI_MODE = TRI_SDR,
    parameter int        TRI_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 div_tick,
    input  logic [P2S_LANE-1:0]  par_d,
    input  logic [P2S_TRI_W-1:0] tri_d,
    input  logic [1:0]           casc_in,
    output logic [1:0]           ser_q,
    output logic [1:0]           tri_q,
    output logic [1:0]           casc_out
);
    localparam bit CFG_OK = cfg_legal(DDR_MODE, WORD_W, ROLE, TRI_MODE, TRI_W);

    generate
        if (!CFG_OK) begin : g_bad_cfg
            $error("par2ser_out: illegal mode/width/role/enable configuration");
        end
    endgenerate

    slot_pair_t data_pair;
    slot_pair_t en_pair;

    p2s_data_shifter #(
        .DDR_MODE (DDR_MODE),
        .WORD_W   (WORD_W),
        .ROLE     (ROLE)
    ) u_data (
        .clk      (clk),
        .rst      (rst),
        .load     (div_tick),
        .par_d    (par_d),
        .casc_in  (casc_in),
        .pair     (data_pair),
        .casc_out (casc_out)
    );

    p2s_tri_shifter #(
        .TRI_MODE (TRI_MODE)
    ) u_en (
        .clk   (clk),
        .rst   (rst),
        .load  (div_tick),
        .tri_d (tri_d),
        .pair  (en_pair)
    );

    assign ser_q = rst ? 2'b00 : data_pair;
    assign tri_q = rst ? 2'b11 : en_pair;

endmodule

// File: rtl/p2s_checker.sv
module p2s_checker
    import p2s_pkg::*;
#(
    parameter bit        DDR_MODE = 1'b0,
    parameter int        WORD_W   = 4,
    parameter role_e     ROLE     = ROLE_MASTER,
    parameter tri_mode_e TRI_MODE = TRI_SDR
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 div_tick,
    input logic [P2S_LANE-1:0]  par_d,
    input logic [P2S_TRI_W-1:0] tri_d,
    input logic [1:0]           ser_q,
    input logic [1:0]           tri_q,
    input logic [1:0]           casc_out
);
    localparam int STEP  = DDR_MODE ? 2 : 1;
    localparam int RATIO = WORD_W / STEP;

    logic [7:0] gap;
    logic       seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (div_tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap <= gap + 8'd1;
        end
    end

    always_comb begin
        if (rst) begin
            AST_RST_SER_LOW: assert (ser_q == 2'b00);   // R3
            AST_RST_TRI_HIGHZ: assert (tri_q == 2'b11); // R3
        end
    end

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (div_tick && seen) |-> (gap == 8'(RATIO - 1)));  // R8

    generate
        if (DDR_MODE) begin : g_first_ddr
            AST_FIRST_PAIR_DDR: assert property (@(posedge clk) disable iff (rst)
                div_tick |=> (ser_q == $past(par_d[1:0])));  // R6
        end else begin : g_first_sdr
            AST_FIRST_PAIR_SDR: assert property (@(posedge clk) disable iff (rst)
                div_tick |=> (ser_q == {2{$past(par_d[0])}}));  // R5
        end

        if (ROLE == ROLE_SLAVE) begin : g_casc
            AST_CASC_HEAD: assert property (@(posedge clk) disable iff (rst)
                div_tick |=> (casc_out[STEP-1:0] == $past(par_d[STEP-1:0])));  // R7
        end

        if (TRI_MODE == TRI_SDR) begin : g_tri_hold
            AST_TRI_HOLD: assert property (@(posedge clk) disable iff (rst)
                (!div_tick && seen) |=> $stable(tri_q));  // R9
        end

        if (TRI_MODE == TRI_DDR) begin : g_tri_ddr
            AST_TRI_DDR_FIRST: assert property (@(posedge clk) disable iff (rst)
                div_tick |=> (tri_q == $past(tri_d[1:0])));  // R10
        end
    endgenerate

endmodule

bind par2ser_out p2s_checker #(
    .DDR_MODE (DDR_MODE),
    .WORD_W   (WORD_W),
    .ROLE     (ROLE),
    .TRI_MODE (TRI_MODE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_tick (div_tick),
    .par_d    (par_d),
    .tri_d    (tri_d),
    .ser_q    (ser_q),
    .tri_q    (tri_q),
    .casc_out (casc_out)
);

// File: tb/par2ser_out_tb.sv
module p2s_cfg_harness
    import p2s_pkg::*;
#(
    parameter bit        DDR = 1'b0,
    parameter int        W   = 4,
    parameter tri_mode_e TM  = TRI_SDR
) (
    input  logic clk,
    input  logic rst,
    output int   checks,
    output int   errs
);
    localparam int STEP  = DDR ? 2 : 1;
    localparam int RATIO = W / STEP;
    localparam bit CASC  = W > 6;
    localparam int TW    = (TM == TRI_DDR) ? 4 : 1;

    logic       tick = 1'b0;
    logic [5:0] pd_m = '0;
    logic [5:0] pd_s = '0;
    logic [3:0] td   = '0;
    logic [1:0] sq, tq, s2m, m_casc;

    par2ser_out #(
        .DDR_MODE (DDR), .WORD_W (W), .ROLE (ROLE_MASTER), .TRI_MODE (TM), .TRI_W (TW)
    ) u_dut (
        .clk (clk), .rst (rst), .div_tick (tick), .par_d (pd_m), .tri_d (td),
        .casc_in (s2m), .ser_q (sq), .tri_q (tq), .casc_out (m_casc)
    );

    generate
        if (CASC) begin : g_slave
            logic [1:0] s_ser, s_tri;
            par2ser_out #(
                .DDR_MODE (DDR), .WORD_W (W), .ROLE (ROLE_SLAVE), .TRI_MODE (TM), .TRI_W (TW)
            ) u_slave (
                .clk (clk), .rst (rst), .div_tick (tick), .par_d (pd_s), .tri_d (td),
                .casc_in (2'b00), .ser_q (s_ser), .tri_q (s_tri), .casc_out (s2m)
            );
        end else begin : g_no_slave
            assign s2m = 2'b00;
        end
    endgenerate

    logic [W-1:0] cur_w = '0;
    logic [W-1:0] drv_w = '0;
    logic [3:0]   cur_td = '0;
    int  ph = 0, k = 0, cyc = 0;
    bit  valid = 0, ticked = 0, rst_prev = 0;
    logic [1:0] exp_d, exp_t;

    initial begin
        checks = 0;
        errs   = 0;
    end

    task automatic check2(input string req, input string what,
                          input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s ddr=%0d w=%0d ph=%0d: actual %b expected %b",
                     req, what, DDR, W, ph, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            if (rst_prev) begin
                check2("R3", "ser_q in reset", sq, 2'b00);
                check2("R3", "tri_q in reset", tq, 2'b11);
            end
            valid  = 0;
            ticked = 0;
            tick   = 1'b0;
        end else begin
            if (ticked) begin
                cur_w  = drv_w;
                cur_td = td;
                ph     = 0;
                valid  = 1;
            end else if (valid) begin
                ph++;
            end
            if (valid) begin
                if (DDR) exp_d = {cur_w[2*ph+1], cur_w[2*ph]};   // R6
                else     exp_d = {cur_w[ph], cur_w[ph]};         // R5
                check2(CASC ? "R7" : (DDR ? "R6" : "R5"), "serial data", sq, exp_d);
                if (TM == TRI_SDR) begin
                    exp_t = {cur_td[0], cur_td[0]};
                    check2("R9", "held enable", tq, exp_t);
                end else if (TM == TRI_DDR) begin
                    exp_t = {cur_td[2*ph+1], cur_td[2*ph]};
                    check2("R10", "ddr enable", tq, exp_t);
                end
            end
            if (TM == TRI_BUF) begin
                exp_t = {td[0], td[0]};
                check2("R11", "pass-through enable", tq, exp_t);
            end
            // R4 / R8: next load strobe exactly when the current word is exhausted
            ticked = !valid || (ph == RATIO - 1);
            tick   = ticked;
            if (ticked) begin
                k++;
                drv_w = W'(k * 157 + 41 + (k >> 3) + W * 11);
                pd_m  = 6'(drv_w);
                pd_s  = 6'(drv_w >> 6);
            end
        end
        td = 4'((cyc * 5 + 3) ^ (cyc >> 1));
        rst_prev = rst;
    end

endmodule

module par2ser_out_tb;
    import p2s_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 600;
    localparam int NCFG       = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   hc [NCFG];
    int   he [NCFG];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    p2s_cfg_harness #(.DDR(1'b0), .W(2),  .TM(TRI_SDR)) h_s2  (.clk(clk), .rst(rst), .checks(hc[0]),  .errs(he[0]));
    p2s_cfg_harness #(.DDR(1'b0), .W(3),  .TM(TRI_SDR)) h_s3  (.clk(clk), .rst(rst), .checks(hc[1]),  .errs(he[1]));
    p2s_cfg_harness #(.DDR(1'b0), .W(4),  .TM(TRI_SDR)) h_s4  (.clk(clk), .rst(rst), .checks(hc[2]),  .errs(he[2]));
    p2s_cfg_harness #(.DDR(1'b0), .W(5),  .TM(TRI_BUF)) h_s5  (.clk(clk), .rst(rst), .checks(hc[3]),  .errs(he[3]));
    p2s_cfg_harness #(.DDR(1'b0), .W(6),  .TM(TRI_SDR)) h_s6  (.clk(clk), .rst(rst), .checks(hc[4]),  .errs(he[4]));
    p2s_cfg_harness #(.DDR(1'b0), .W(7),  .TM(TRI_SDR)) h_s7  (.clk(clk), .rst(rst), .checks(hc[5]),  .errs(he[5]));
    p2s_cfg_harness #(.DDR(1'b0), .W(8),  .TM(TRI_BUF)) h_s8  (.clk(clk), .rst(rst), .checks(hc[6]),  .errs(he[6]));
    p2s_cfg_harness #(.DDR(1'b1), .W(4),  .TM(TRI_DDR)) h_d4  (.clk(clk), .rst(rst), .checks(hc[7]),  .errs(he[7]));
    p2s_cfg_harness #(.DDR(1'b1), .W(6),  .TM(TRI_BUF)) h_d6  (.clk(clk), .rst(rst), .checks(hc[8]),  .errs(he[8]));
    p2s_cfg_harness #(.DDR(1'b1), .W(8),  .TM(TRI_SDR)) h_d8  (.clk(clk), .rst(rst), .checks(hc[9]),  .errs(he[9]));
    p2s_cfg_harness #(.DDR(1'b1), .W(10), .TM(TRI_BUF)) h_d10 (.clk(clk), .rst(rst), .checks(hc[10]), .errs(he[10]));

    task automatic check_bit(input string req, input string what, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        for (int i = 0; i < NCFG; i++) begin
            n_checks += hc[i];
            n_errors += he[i];
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // R1 and R2: legality sweep against an independent list of permitted settings
    initial begin
        for (int w = 1; w <= 12; w++) begin
            for (int d = 0; d < 2; d++) begin
                bit exp_ok;
                if (d == 1) exp_ok = (w == 4 || w == 6 || w == 8 || w == 10);
                else        exp_ok = (w >= 2 && w <= 8);
                check_bit("R1", $sformatf("data width ok d=%0d w=%0d", d, w),
                          data_width_ok(d[0], w), exp_ok);
                check_bit("R1", $sformatf("slave legal d=%0d w=%0d", d, w),
                          cfg_legal(d[0], w, ROLE_SLAVE, TRI_SDR, 1), exp_ok && (w > 6));
                for (int tw = 1; tw <= 5; tw++) begin
                    check_bit("R2", $sformatf("buf enable w=%0d tw=%0d", w, tw),
                              tri_width_ok(TRI_BUF, d[0], w, tw), tw == 1);
                    check_bit("R2", $sformatf("held enable w=%0d tw=%0d", w, tw),
                              tri_width_ok(TRI_SDR, d[0], w, tw), tw == 1);
                    check_bit("R2", $sformatf("ddr enable d=%0d w=%0d tw=%0d", d, w, tw),
                              tri_width_ok(TRI_DDR, d[0], w, tw), (tw == 4) && (d == 1) && (w == 4));
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (RUN_CYCLES / 2) @(posedge clk);
        #1 rst = 1'b1;                      // R3: mid-run reset
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (RUN_CYCLES / 2) @(posedge clk);
        done = 1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * (RUN_CYCLES + 2000));
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule